// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a bus fabric and decides, for every access it is shown, whether that access may proceed. Twelve programmable regions each cover an inclusive span of 32-byte blocks. Each region carries a set of rights for every bus master. It can also require a process identifier, compared under a mask. Three access ports are judged side by side in the same cycle. Each port gets a grant or a protection error with no register in the path.

Descriptors are loaded one region at a time through a write strobe and take effect at the next clock edge. When a port's access is refused, the block keeps a record of that access: its address, master, kind and region hit vector. The record is held until software acknowledges it, and later refusals on that port are dropped until then. Processor masters are told apart from other masters by their identifier. Only processor masters are checked for execute rights and for supervisor or user privilege.

Top module: `mpu_guard`

## Requirements
- R1: After reset every region is invalid, so every presented access is refused, and all sticky error flags read 0.
- R2: A region holds start and end block numbers (address bits 31:5). An access hits when its block lies between them, both ends included. Address bits 4:0 never affect the decision.
- R3: Where regions overlap, an access is granted if at least one region it hits allows the requested kind; regions that hit but do not allow it do not veto.
- R4: Each master owns 6 rights bits in each region, at `cfg_rights[6*m +: 6]`. Bit 0 is user read, bit 1 user write, bit 2 user execute, bit 3 supervisor read, bit 4 supervisor write and bit 5 supervisor execute. For masters with ID below NUM_CPU (processor masters), `acc_super` selects the supervisor half. For other masters only bits 0 and 1 count, privilege is ignored and execute is always refused.
- R5: When the region's PID enable is set, the region applies only if `acc_pid` equals the stored PID on every bit whose mask bit is 0. A mask bit of 1 makes that bit a don't-care.
- R6: The three ports are checked independently and at the same time, and the grant or error follows the port inputs combinationally.
- R7: An access that hits no valid region is refused. Access kind encoding is 00 read, 01 write, 10 execute. Kind 11 is always refused.
- R8: At the clock edge after a refused access on a port whose flag is clear, that port's flag is set and the record holds the access's full address, master, kind and 12-bit region hit vector.
- R9: While a port's flag is set, further refusals leave its record unchanged. Raising `err_clr` for that port clears the flag at the next edge, and clearing takes precedence over a same-cycle refusal.
- R10: A descriptor write with `cfg_idx` below 12 replaces that whole region at the next clock edge. Accesses in the cycle of the write still see the old descriptor.
- R11: A port with `acc_valid` low drives neither grant nor error and records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 4 | Region number to write |
| cfg_valid | input | 1 | Region valid bit to store |
| cfg_start | input | 27 | First block number of the region |
| cfg_end | input | 27 | Last block number of the region (inclusive) |
| cfg_pid_en | input | 1 | Region requires a PID match |
| cfg_pid | input | 8 | Stored PID |
| cfg_pid_mask | input | 8 | PID don't-care mask |
| cfg_rights | input | 24 | Six rights bits per master |
| acc_valid | input | 3 | Per-port access present |
| acc_addr | input | 96 | Per-port byte address, 32 bits each |
| acc_master | input | 6 | Per-port master ID, 2 bits each |
| acc_kind | input | 6 | Per-port access kind, 2 bits each |
| acc_super | input | 3 | Per-port supervisor mode |
| acc_pid | input | 24 | Per-port PID, 8 bits each |
| grant | output | 3 | Per-port access allowed |
| prot_err | output | 3 | Per-port access refused |
| err_clr | input | 3 | Per-port sticky error acknowledge |
| err_flag | output | 3 | Per-port sticky error flag |
| err_addr | output | 96 | Per-port recorded address |
| err_master | output | 6 | Per-port recorded master ID |
| err_kind | output | 6 | Per-port recorded access kind |
| err_hits | output | 36 | Per-port recorded region hit vector, 12 bits each |

## Verification
The assertions check on every cycle the following properties:
- no grant is given without at least one region hit;
- a refusal with a clear flag produces a record of that exact address at the next edge;
- a set flag survives and freezes its record until acknowledged;
- an idle port never sets its flag;
- a descriptor write lands in the addressed region.

Only the bench's scenarios can show that the decision itself is right: the inclusive 32-byte boundaries, the rights bit chosen for each master, kind and privilege, the any-region-grants rule for overlaps, the masked PID comparison, and the one-cycle delay before a new descriptor is seen.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

  localparam int RIGHTS_W = 6;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  // Position of the rights bit for a processor master.
  function automatic logic [2:0] cpu_right_idx(input logic [1:0] kind, input logic sup);
    cpu_right_idx = {1'b0, kind} + (sup ? 3'd3 : 3'd0);
  endfunction

endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import mpu_pkg::*;
#(
  parameter int BLK_W       = 27,
  parameter int PID_W       = 8,
  parameter int NUM_MASTERS = 4,
  parameter int NUM_CPU     = 2,
  parameter int MID_W       = 2
) (
  input  logic                                     rg_valid,
  input  logic [BLK_W-1:0]                         rg_start,
  input  logic [BLK_W-1:0]                         rg_end,
  input  logic                                     rg_pid_en,
  input  logic [PID_W-1:0]                         rg_pid,
  input  logic [PID_W-1:0]                         rg_pid_mask,
  input  logic [NUM_MASTERS-1:0][RIGHTS_W-1:0]     rg_rights,
  input  logic [BLK_W-1:0]                         acc_blk,
  input  logic [MID_W-1:0]                         acc_master,
  input  logic [1:0]                               acc_kind,
  input  logic                                     acc_super,
  input  logic [PID_W-1:0]                         acc_pid,
  output logic                                     hit,
  output logic                                     permit
);

  localparam logic [MID_W:0] CPU_LIM = (MID_W+1)'(NUM_CPU);
  localparam logic [MID_W:0] MST_LIM = (MID_W+1)'(NUM_MASTERS);

  logic                in_range;
  logic                pid_ok;
  logic                is_cpu;
  logic                mst_ok;
  logic [RIGHTS_W-1:0] mst_rights;

  assign in_range = (acc_blk >= rg_start) && (acc_blk <= rg_end);
  assign pid_ok   = !rg_pid_en || (((acc_pid ^ rg_pid) & ~rg_pid_mask) == '0);
  assign hit      = rg_valid && in_range && pid_ok;

  assign mst_ok = ({1'b0, acc_master} < MST_LIM);
  assign is_cpu = ({1'b0, acc_master} < CPU_LIM);

  always_comb begin
    mst_rights = '0;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (acc_master == MID_W'(m)) mst_rights = rg_rights[m];
    end
  end

  always_comb begin
    permit = 1'b0;
    if (mst_ok && acc_kind != ACC_RSVD) begin
      if (is_cpu) begin
        permit = mst_rights[cpu_right_idx(acc_kind, acc_super)];
      end else if (acc_kind != ACC_EXEC) begin
        permit = mst_rights[acc_kind[0]];
      end
    end
  end

endmodule

// File: rtl/mpu_port_check.sv
module mpu_port_check
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 12,
  parameter int BLK_W       = 27,
  parameter int PID_W       = 8,
  parameter int NUM_MASTERS = 4,
  parameter int NUM_CPU     = 2,
  parameter int MID_W       = 2
) (
  input  logic [NUM_REGIONS-1:0]                              rg_valid,
  input  logic [NUM_REGIONS-1:0][BLK_W-1:0]                   rg_start,
  input  logic [NUM_REGIONS-1:0][BLK_W-1:0]                   rg_end,
  input  logic [NUM_REGIONS-1:0]                              rg_pid_en,
  input  logic [NUM_REGIONS-1:0][PID_W-1:0]                   rg_pid,
  input  logic [NUM_REGIONS-1:0][PID_W-1:0]                   rg_pid_mask,
  input  logic [NUM_REGIONS-1:0][NUM_MASTERS-1:0][RIGHTS_W-1:0] rg_rights,
  input  logic                                                acc_valid,
  input  logic [BLK_W-1:0]                                    acc_blk,
  input  logic [MID_W-1:0]                                    acc_master,
  input  logic [1:0]                                          acc_kind,
  input  logic                                                acc_super,
  input  logic [PID_W-1:0]                                    acc_pid,
  output logic                                                grant,
  output logic                                                prot_err,
  output logic [NUM_REGIONS-1:0]                              hit_vec
);

  logic [NUM_REGIONS-1:0] perm_vec;
  logic                   allowed;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    mpu_region_match #(
      .BLK_W(BLK_W), .PID_W(PID_W), .NUM_MASTERS(NUM_MASTERS),
      .NUM_CPU(NUM_CPU), .MID_W(MID_W)
    ) u_match (
      .rg_valid   (rg_valid[r]),
      .rg_start   (rg_start[r]),
      .rg_end     (rg_end[r]),
      .rg_pid_en  (rg_pid_en[r]),
      .rg_pid     (rg_pid[r]),
      .rg_pid_mask(rg_pid_mask[r]),
      .rg_rights  (rg_rights[r]),
      .acc_blk    (acc_blk),
      .acc_master (acc_master),
      .acc_kind   (acc_kind),
      .acc_super  (acc_super),
      .acc_pid    (acc_pid),
      .hit        (hit_vec[r]),
      .permit     (perm_vec[r])
    );
  end

  // Any hitting region that permits the access is enough.
  assign allowed  = |(hit_vec & perm_vec);
  assign grant    = acc_valid && allowed;
  assign prot_err = acc_valid && !allowed;

endmodule

// File: rtl/mpu_err_capture.sv
module mpu_err_capture #(
  parameter int ADDR_W      = 32,
  parameter int MID_W       = 2,
  parameter int NUM_REGIONS = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  input  logic                   deny,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [MID_W-1:0]       acc_master,
  input  logic [1:0]             acc_kind,
  input  logic [NUM_REGIONS-1:0] hit_vec,
  input  logic                   err_clr,
  output logic                   err_flag,
  output logic [ADDR_W-1:0]      err_addr,
  output logic [MID_W-1:0]       err_master,
  output logic [1:0]             err_kind,
  output logic [NUM_REGIONS-1:0] err_hits
);

  logic flag_q, flag_nx;
  logic cap_en;

  always_comb begin
    flag_nx = flag_q;
    cap_en  = 1'b0;
    if (err_clr) begin
      flag_nx = 1'b0;
    end else if (deny && !flag_q) begin
      flag_nx = 1'b1;
      cap_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q     <= 1'b0;
      err_addr   <= '0;
      err_master <= '0;
      err_kind   <= '0;
      err_hits   <= '0;
    end else begin
      flag_q <= flag_nx;
      if (cap_en) begin
        err_addr   <= acc_addr;
        err_master <= acc_master;
        err_kind   <= acc_kind;
        err_hits   <= hit_vec;
      end
    end
  end

  assign err_flag = flag_q;

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (deny && !err_flag && !err_clr) |=> (err_flag && err_addr == $past(acc_addr)))
    else $error("refused access not recorded");

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> (err_flag && $stable(err_addr) && $stable(err_hits)))
    else $error("sticky record disturbed");

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !err_flag) |=> !err_flag)
    else $error("idle port raised its flag");

endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 12,
  parameter int NUM_PORTS   = 3,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 5,
  parameter int NUM_MASTERS = 4,
  parameter int NUM_CPU     = 2,
  parameter int PID_W       = 8,
  localparam int BLK_W = ADDR_W - GRAN_BITS,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int MID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int RT_W  = NUM_MASTERS * RIGHTS_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic                          cfg_valid,
  input  logic [BLK_W-1:0]              cfg_start,
  input  logic [BLK_W-1:0]              cfg_end,
  input  logic                          cfg_pid_en,
  input  logic [PID_W-1:0]              cfg_pid,
  input  logic [PID_W-1:0]              cfg_pid_mask,
  input  logic [RT_W-1:0]               cfg_rights,
  input  logic [NUM_PORTS-1:0]          acc_valid,
  input  logic [NUM_PORTS*ADDR_W-1:0]   acc_addr,
  input  logic [NUM_PORTS*MID_W-1:0]    acc_master,
  input  logic [NUM_PORTS*2-1:0]        acc_kind,
  input  logic [NUM_PORTS-1:0]          acc_super,
  input  logic [NUM_PORTS*PID_W-1:0]    acc_pid,
  output logic [NUM_PORTS-1:0]          grant,
  output logic [NUM_PORTS-1:0]          prot_err,
  input  logic [NUM_PORTS-1:0]          err_clr,
  output logic [NUM_PORTS-1:0]          err_flag,
  output logic [NUM_PORTS*ADDR_W-1:0]   err_addr,
  output logic [NUM_PORTS*MID_W-1:0]    err_master,
  output logic [NUM_PORTS*2-1:0]        err_kind,
  output logic [NUM_PORTS*NUM_REGIONS-1:0] err_hits
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_n, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  // Descriptor storage.
  logic [NUM_REGIONS-1:0]                                rg_valid,    rg_valid_nx;
  logic [NUM_REGIONS-1:0][BLK_W-1:0]                     rg_start,    rg_start_nx;
  logic [NUM_REGIONS-1:0][BLK_W-1:0]                     rg_end,      rg_end_nx;
  logic [NUM_REGIONS-1:0]                                rg_pid_en,   rg_pid_en_nx;
  logic [NUM_REGIONS-1:0][PID_W-1:0]                     rg_pid,      rg_pid_nx;
  logic [NUM_REGIONS-1:0][PID_W-1:0]                     rg_pid_mask, rg_pid_mask_nx;
  logic [NUM_REGIONS-1:0][NUM_MASTERS-1:0][RIGHTS_W-1:0] rg_rights,   rg_rights_nx;

  always_comb begin
    rg_valid_nx    = rg_valid;
    rg_start_nx    = rg_start;
    rg_end_nx      = rg_end;
    rg_pid_en_nx   = rg_pid_en;
    rg_pid_nx      = rg_pid;
    rg_pid_mask_nx = rg_pid_mask;
    rg_rights_nx   = rg_rights;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (cfg_idx == IDX_W'(r)) begin
        rg_valid_nx[r]    = cfg_valid;
        rg_start_nx[r]    = cfg_start;
        rg_end_nx[r]      = cfg_end;
        rg_pid_en_nx[r]   = cfg_pid_en;
        rg_pid_nx[r]      = cfg_pid;
        rg_pid_mask_nx[r] = cfg_pid_mask;
        rg_rights_nx[r]   = cfg_rights;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rg_valid    <= '0;
      rg_start    <= '0;
      rg_end      <= '0;
      rg_pid_en   <= '0;
      rg_pid      <= '0;
      rg_pid_mask <= '0;
      rg_rights   <= '0;
    end else if (cfg_we) begin
      rg_valid    <= rg_valid_nx;
      rg_start    <= rg_start_nx;
      rg_end      <= rg_end_nx;
      rg_pid_en   <= rg_pid_en_nx;
      rg_pid      <= rg_pid_nx;
      rg_pid_mask <= rg_pid_mask_nx;
      rg_rights   <= rg_rights_nx;
    end
  end

  assert_desc_write_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cfg_we && ({1'b0, cfg_idx} < (IDX_W+1)'(NUM_REGIONS)))
      |=> (rg_valid[$past(cfg_idx)] == $past(cfg_valid) &&
           rg_start[$past(cfg_idx)] == $past(cfg_start)))
    else $error("descriptor write not applied");

  // Per-port checkers and error records.
  logic [NUM_PORTS-1:0][NUM_REGIONS-1:0] hits_w;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mpu_port_check #(
      .NUM_REGIONS(NUM_REGIONS), .BLK_W(BLK_W), .PID_W(PID_W),
      .NUM_MASTERS(NUM_MASTERS), .NUM_CPU(NUM_CPU), .MID_W(MID_W)
    ) u_chk (
      .rg_valid   (rg_valid),
      .rg_start   (rg_start),
      .rg_end     (rg_end),
      .rg_pid_en  (rg_pid_en),
      .rg_pid     (rg_pid),
      .rg_pid_mask(rg_pid_mask),
      .rg_rights  (rg_rights),
      .acc_valid  (acc_valid[p]),
      .acc_blk    (acc_addr[p*ADDR_W+GRAN_BITS +: BLK_W]),
      .acc_master (acc_master[p*MID_W +: MID_W]),
      .acc_kind   (acc_kind[p*2 +: 2]),
      .acc_super  (acc_super[p]),
      .acc_pid    (acc_pid[p*PID_W +: PID_W]),
      .grant      (grant[p]),
      .prot_err   (prot_err[p]),
      .hit_vec    (hits_w[p])
    );

    mpu_err_capture #(
      .ADDR_W(ADDR_W), .MID_W(MID_W), .NUM_REGIONS(NUM_REGIONS)
    ) u_cap (
      .clk       (clk),
      .rst_n     (rst_q_n),
      .acc_valid (acc_valid[p]),
      .deny      (prot_err[p]),
      .acc_addr  (acc_addr[p*ADDR_W +: ADDR_W]),
      .acc_master(acc_master[p*MID_W +: MID_W]),
      .acc_kind  (acc_kind[p*2 +: 2]),
      .hit_vec   (hits_w[p]),
      .err_clr   (err_clr[p]),
      .err_flag  (err_flag[p]),
      .err_addr  (err_addr[p*ADDR_W +: ADDR_W]),
      .err_master(err_master[p*MID_W +: MID_W]),
      .err_kind  (err_kind[p*2 +: 2]),
      .err_hits  (err_hits[p*NUM_REGIONS +: NUM_REGIONS])
    );

    assert_grant_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
      grant[p] |-> (hits_w[p] != '0))
      else $error("grant without any region hit");
  end

endmodule

// File: tb/tb_mpu_guard.sv
module tb_mpu_guard;

  localparam int NR = 12;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic           cfg_we = 1'b0;
  logic [3:0]     cfg_idx = '0;
  logic           cfg_valid = 1'b0;
  logic [26:0]    cfg_start = '0, cfg_end = '0;
  logic           cfg_pid_en = 1'b0;
  logic [7:0]     cfg_pid = '0, cfg_pid_mask = '0;
  logic [23:0]    cfg_rights = '0;
  logic [NP-1:0]  acc_valid, acc_super;
  logic [95:0]    acc_addr;
  logic [5:0]     acc_master, acc_kind;
  logic [23:0]    acc_pid;
  logic [NP-1:0]  grant, prot_err, err_flag;
  logic [NP-1:0]  err_clr = '0;
  logic [95:0]    err_addr;
  logic [5:0]     err_master, err_kind;
  logic [35:0]    err_hits;

  // Per-port stimulus
  logic        p_v[NP];
  logic [31:0] p_addr[NP];
  logic [1:0]  p_m[NP], p_k[NP];
  logic        p_s[NP];
  logic [7:0]  p_pid[NP];

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      acc_valid[p]         = p_v[p];
      acc_addr[p*32 +: 32] = p_addr[p];
      acc_master[p*2 +: 2] = p_m[p];
      acc_kind[p*2 +: 2]   = p_k[p];
      acc_super[p]         = p_s[p];
      acc_pid[p*8 +: 8]    = p_pid[p];
    end
  end

  mpu_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_pid_en(cfg_pid_en), .cfg_pid(cfg_pid),
    .cfg_pid_mask(cfg_pid_mask), .cfg_rights(cfg_rights), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_master(acc_master), .acc_kind(acc_kind), .acc_super(acc_super),
    .acc_pid(acc_pid), .grant(grant), .prot_err(prot_err), .err_clr(err_clr),
    .err_flag(err_flag), .err_addr(err_addr), .err_master(err_master), .err_kind(err_kind),
    .err_hits(err_hits)
  );

  // Shadow descriptors (bench model)
  logic        sh_v[NR];
  logic [26:0] sh_st[NR], sh_en[NR];
  logic        sh_pe[NR];
  logic [7:0]  sh_pid[NR], sh_mk[NR];
  logic [23:0] sh_rt[NR];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  function automatic bit model_ok(logic [31:0] a, logic [1:0] m, logic [1:0] k, logic s, logic [7:0] pid);
    logic [5:0] rt;
    bit perm;
    for (int r = 0; r < NR; r++) begin
      if (sh_v[r] && a[31:5] >= sh_st[r] && a[31:5] <= sh_en[r] &&
          (!sh_pe[r] || ((pid ^ sh_pid[r]) & ~sh_mk[r]) == 8'h00)) begin
        rt = sh_rt[r][m*6 +: 6];
        perm = 1'b0;
        if (k == 2'b11) perm = 1'b0;
        else if (m < 2) perm = rt[(s ? 3 : 0) + k];
        else if (k != 2'b10) perm = rt[k[0]];
        if (perm) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic check(bit cond, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, then compare the combinational result.
  task automatic eval_all(string req);
    bit e;
    @(negedge clk);
    #1;
    for (int p = 0; p < NP; p++) begin
      e = p_v[p] && model_ok(p_addr[p], p_m[p], p_k[p], p_s[p], p_pid[p]);
      check(grant[p] == e && prot_err[p] == (p_v[p] && !e), req, $sformatf("port%0d grant/err", p),
            {grant[p], prot_err[p]}, {e, p_v[p] && !e});
    end
  endtask

  task automatic wr_region(int idx, bit v, logic [26:0] st, logic [26:0] en, bit pe,
                           logic [7:0] pid, logic [7:0] mk, logic [23:0] rt);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_valid = v; cfg_start = st; cfg_end = en;
    cfg_pid_en = pe; cfg_pid = pid; cfg_pid_mask = mk; cfg_rights = rt;
    @(negedge clk);
    cfg_we = 1'b0;
    sh_v[idx] = v; sh_st[idx] = st; sh_en[idx] = en; sh_pe[idx] = pe;
    sh_pid[idx] = pid; sh_mk[idx] = mk; sh_rt[idx] = rt;
  endtask

  task automatic set_port(int p, bit v, logic [31:0] a, logic [1:0] m, logic [1:0] k, bit s, logic [7:0] pid);
    p_v[p] = v; p_addr[p] = a; p_m[p] = m; p_k[p] = k; p_s[p] = s; p_pid[p] = pid;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    for (int p = 0; p < NP; p++) p_v[p] = 1'b0;
    err_clr = '1;
    @(negedge clk);
    err_clr = '0;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<50000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      sh_v[r] = 0; sh_st[r] = 0; sh_en[r] = 0; sh_pe[r] = 0; sh_pid[r] = 0; sh_mk[r] = 0; sh_rt[r] = 0;
    end
    for (int p = 0; p < NP; p++) set_port(p, 1'b0, 32'h0, 2'd0, 2'd0, 1'b0, 8'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, then every access refused
    check(err_flag == 3'b000, "R1", "flags after reset", 64'(err_flag), 64'h0);
    check(grant == 3'b000 && prot_err == 3'b000, "R1", "idle outputs", 64'({grant, prot_err}), 64'h0);
    set_port(0, 1'b1, 32'h0000_0200, 2'd0, 2'd0, 1'b1, 8'h0);
    set_port(1, 1'b1, 32'h1234_5678, 2'd2, 2'd1, 1'b0, 8'h0);
    set_port(2, 1'b1, 32'hFFFF_FFE0, 2'd1, 2'd2, 1'b1, 8'h0);
    eval_all("R1");

    // R2/R6: boundary sweep on region 0 (blocks 0x10..0x1F, all rights)
    wr_region(0, 1'b1, 27'h10, 27'h1F, 1'b0, 8'h0, 8'h0, 24'hFFFFFF);
    for (int b = 'h0E; b <= 'h21; b++) begin
      for (int lo = 0; lo < 2; lo++) begin
        set_port(0, 1'b1, {27'(b), (lo != 0) ? 5'd31 : 5'd0}, 2'd0, 2'd0, 1'b1, 8'h0);
        set_port(1, 1'b1, {27'(b), 5'd17}, 2'd1, 2'd0, 1'b0, 8'h0);
        set_port(2, 1'b1, {27'(b + 1), (lo != 0) ? 5'd0 : 5'd31}, 2'd3, 2'd1, 1'b0, 8'h0);
        eval_all("R2/R6");
      end
    end

    // R4/R7: rights decode sweep, region 1 blocks 0x100..0x1FF
    // master0 101001, master1 010110, master2 000001, master3 000010
    wr_region(1, 1'b1, 27'h100, 27'h1FF, 1'b0, 8'h0, 8'h0, {6'b000010, 6'b000001, 6'b010110, 6'b101001});
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < 2; s++) begin
          set_port(0, 1'b1, 32'h0000_2400, 2'(m), 2'(k), 1'(s), 8'h0);
          set_port(1, 1'b1, 32'h0000_3FE4, 2'(m), 2'(k), !1'(s), 8'h0);
          set_port(2, 1'b1, 32'h0000_4000 + 32'(m * 32), 2'(m), 2'(k), 1'(s), 8'h0);
          eval_all("R4/R7");
        end

    // R3: overlap, region 2 blocks 0x180..0x18F gives master2 write only
    wr_region(2, 1'b1, 27'h180, 27'h18F, 1'b0, 8'h0, 8'h0, {6'b000000, 6'b000010, 6'b000000, 6'b000000});
    set_port(0, 1'b1, 32'h0000_30A0, 2'd2, 2'd1, 1'b0, 8'h0); // in overlap: write via region 2
    set_port(1, 1'b1, 32'h0000_30A0, 2'd2, 2'd0, 1'b0, 8'h0); // in overlap: read via region 1
    set_port(2, 1'b1, 32'h0000_3400, 2'd2, 2'd1, 1'b0, 8'h0); // outside overlap: write refused
    eval_all("R3");
    check(grant == 3'b011, "R3", "overlap grant pattern", 64'(grant), 64'h3);
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 3; k++) begin
        set_port(0, 1'b1, 32'h0000_3000, 2'(m), 2'(k), 1'b0, 8'h0);
        set_port(1, 1'b1, 32'h0000_31FF, 2'(m), 2'(k), 1'b1, 8'h0);
        set_port(2, 1'b1, 32'h0000_3200, 2'(m), 2'(k), 1'b0, 8'h0);
        eval_all("R3");
      end

    // R5: PID qualifier sweep, region 3 blocks 0x400..0x4FF, pid 0x5A mask 0x0F
    wr_region(3, 1'b1, 27'h400, 27'h4FF, 1'b1, 8'h5A, 8'h0F, 24'hFFFFFF);
    for (int v = 0; v < 256; v++) begin
      set_port(0, 1'b1, 32'h0000_8000, 2'd0, 2'd0, 1'b0, 8'(v));
      set_port(1, 1'b1, 32'h0000_9FE0, 2'd3, 2'd1, 1'b1, 8'(v ^ 8'h5A));
      set_port(2, 1'b1, 32'h0000_8100, 2'd1, 2'd2, 1'b1, 8'(255 - v));
      eval_all("R5");
    end
    set_port(0, 1'b1, 32'h0000_8000, 2'd0, 2'd0, 1'b0, 8'h53);
    set_port(1, 1'b1, 32'h0000_8000, 2'd0, 2'd0, 1'b0, 8'h6A);
    @(negedge clk); #1;
    check(grant[1:0] == 2'b01, "R5", "masked pid match", 64'(grant[1:0]), 64'h1);

    // R10: descriptor takes effect at the next edge only
    @(negedge clk);
    set_port(0, 1'b1, 32'h0001_0000, 2'd0, 2'd0, 1'b0, 8'h0);
    cfg_we = 1'b1; cfg_idx = 4'd4; cfg_valid = 1'b1; cfg_start = 27'h800; cfg_end = 27'h800;
    cfg_pid_en = 1'b0; cfg_pid = 8'h0; cfg_pid_mask = 8'h0; cfg_rights = 24'hFFFFFF;
    #1;
    check(grant[0] == 1'b0, "R10", "old descriptor in write cycle", 64'(grant[0]), 64'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check(grant[0] == 1'b1, "R10", "new descriptor after edge", 64'(grant[0]), 64'h1);
    sh_v[4] = 1; sh_st[4] = 27'h800; sh_en[4] = 27'h800; sh_pe[4] = 0; sh_pid[4] = 0; sh_mk[4] = 0; sh_rt[4] = 24'hFFFFFF;
    // out-of-range index writes nothing
    wr_region(13, 1'b0, 27'h0, 27'h0, 1'b0, 8'h0, 8'h0, 24'h0);
    sh_v[4] = 1'b1;
    set_port(0, 1'b1, 32'h0001_001C, 2'd0, 2'd0, 1'b0, 8'h0);
    eval_all("R10");

    // R11: idle port on a refused address records nothing
    clear_flags();
    set_port(0, 1'b0, 32'hDEAD_0000, 2'd3, 2'd3, 1'b0, 8'h0);
    set_port(1, 1'b0, 32'hDEAD_0000, 2'd3, 2'd3, 1'b0, 8'h0);
    set_port(2, 1'b0, 32'hDEAD_0000, 2'd3, 2'd3, 1'b0, 8'h0);
    eval_all("R11");
    repeat (2) @(negedge clk);
    check(err_flag == 3'b000, "R11", "no flag from idle ports", 64'(err_flag), 64'h0);

    // R8: capture on port 1 (master3 read in region 1 only -> hits 0x002)
    @(negedge clk);
    set_port(1, 1'b1, 32'h0000_2004, 2'd3, 2'd0, 1'b0, 8'h0);
    @(negedge clk);
    set_port(1, 1'b0, 32'h0, 2'd0, 2'd0, 1'b0, 8'h0);
    #1;
    check(err_flag == 3'b010, "R8", "flag set on port1 only", 64'(err_flag), 64'h2);
    check(err_addr[63:32] == 32'h0000_2004, "R8", "recorded address", 64'(err_addr[63:32]), 64'h2004);
    check(err_master[3:2] == 2'd3 && err_kind[3:2] == 2'd0, "R8", "recorded master/kind",
          64'({err_master[3:2], err_kind[3:2]}), 64'hC);
    check(err_hits[23:12] == 12'h002, "R8", "recorded hit vector", 64'(err_hits[23:12]), 64'h2);

    // R9: second refusal must not overwrite
    set_port(1, 1'b1, 32'h0000_7000, 2'd2, 2'd2, 1'b0, 8'h0);
    repeat (2) @(negedge clk);
    #1;
    check(err_flag[1] && err_addr[63:32] == 32'h0000_2004, "R9", "record held",
          64'(err_addr[63:32]), 64'h2004);
    // clear wins over same-cycle refusal
    err_clr[1] = 1'b1;
    @(negedge clk);
    err_clr[1] = 1'b0;
    #1;
    check(err_flag[1] == 1'b0, "R9", "flag cleared", 64'(err_flag[1]), 64'h0);
    @(negedge clk);
    set_port(1, 1'b0, 32'h0, 2'd0, 2'd0, 1'b0, 8'h0);
    #1;
    check(err_flag[1] && err_addr[63:32] == 32'h0000_7000 && err_kind[3:2] == 2'd2, "R9",
          "new record after clear", 64'(err_addr[63:32]), 64'h7000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule